// File: doc/BRIEF.md
# Fractional Divider Field Encoder

This block turns a requested output-divider ratio into the counter fields that a clock synthesizer's output divider is programmed with. The ratio arrives as an integer part and a fraction in eighths. The block produces these fields: high and low counts, the odd-ratio edge bit, the bypass (no-count) bit, the fractional enable, the fraction value, the rising and falling waveform adjust bits, and the fractional phase. It also packs them into three 16-bit configuration words.

A request is presented with `in_valid`. One clock later the block shows the encoded fields and packed words with `out_valid`, and it holds them until the next request arrives. Both fractional mode and integer mode start from a plain split of the ratio into high and low counts. In fractional mode, the high and low counts are then decremented and the waveform adjust bits are set, depending on the parity of the ratio and on the fraction. An integer ratio of zero, or one too large for the 6-bit counts, is flagged as invalid.

Top module: `frac_div_encoder`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high in the following cycle with the encoded result. Cycles without `in_valid` drop `out_valid` and leave every field and word unchanged.
- R2: After synchronous reset, all outputs are zero.
- R3: An integer ratio of 1 sets only the bypass bit, whatever the fraction is. All other fields are zero.
- R4: With a zero fraction and an integer ratio N ≥ 2, high = N/2, edge = N mod 2 and low = N − high. Fractional enable, fraction, waveform bits and phase are all zero.
- R5: With a nonzero fraction F and N ≥ 2, fractional enable is 1 and the fraction output equals F. Edge = N mod 2, and high and low both start at N/2.
- R6: In fractional mode with an even N, high is one less than N/2 and the rising waveform bit is 1. With an odd N, the rising bit is 0.
- R7: In fractional mode, low is decremented by one from N/2 when N is even or when F = 1.
- R8: In fractional mode, the falling waveform bit is set when (N even) XOR (F = 1), and also when N = 2 and F = 1.
- R9: In fractional mode, phase = 4·edge + F/2, using integer division.
- R10: Word 1 holds high in bits 11:6 and low in bits 5:0. All other bits are zero.
- R11: Word 2 holds the fraction in bits 14:12, fractional enable in bit 11, the rising bit in bit 10, edge in bit 7 and bypass in bit 6. All other bits are zero.
- R12: Word 3 holds the phase in bits 13:11 and the falling bit in bit 10. All other bits are zero.
- R13: An integer ratio of 0, or one above 126, raises `bad_div` and forces every field and word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| div_int | input | 7 | Integer part of the ratio |
| div_frac | input | 3 | Fraction of the ratio in eighths |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| hi_cnt | output | 6 | High count |
| lo_cnt | output | 6 | Low count |
| edge_bit | output | 1 | Odd-ratio edge bit |
| bypass | output | 1 | No-count bypass bit |
| frac_en | output | 1 | Fractional mode enable |
| frac_val | output | 3 | Fraction value |
| wf_rise | output | 1 | Rising waveform adjust |
| wf_fall | output | 1 | Falling waveform adjust |
| frac_phase | output | 3 | Fractional phase |
| cfg_word1 | output | 16 | Packed counts word |
| cfg_word2 | output | 16 | Packed mode word |
| cfg_word3 | output | 16 | Packed phase word |
| bad_div | output | 1 | Invalid ratio flag |

## Verification
The bench targets the corners where the fractional rules interact. At N = 2 with F = 1, a design that misses the special case leaves the falling bit clear and drives high and low both to zero. Odd and even ratios are each combined with F = 1 and with other fractions, which exposes a wrong XOR polarity or an inverted low-decrement condition. The checks also cover ratio 1 with a nonzero fraction, which a careless design encodes as fractional. They cover ratios 0, 126 and 127, where a missing range check would wrap the low count, and the hold behaviour between requests.

// File: rtl/fde_pkg.sv
package fde_pkg;
  localparam int FDE_CNT_W  = 6;
  localparam int FDE_FRAC_W = 3;
  localparam int FDE_DIV_W  = FDE_CNT_W + 1;
  localparam int FDE_WORD_W = 16;

  // word 1 layout
  localparam int W1_LO_LSB = 0;
  localparam int W1_HI_LSB = 6;
  // word 2 layout
  localparam int W2_NOCNT_BIT = 6;
  localparam int W2_EDGE_BIT  = 7;
  localparam int W2_WFR_BIT   = 10;
  localparam int W2_FEN_BIT   = 11;
  localparam int W2_FRAC_LSB  = 12;
  // word 3 layout
  localparam int W3_WFF_BIT   = 10;
  localparam int W3_PHASE_LSB = 11;

  typedef struct packed {
    logic [FDE_CNT_W-1:0]  hi;
    logic [FDE_CNT_W-1:0]  lo;
    logic                  edge_b;
    logic                  nocnt;
    logic                  fen;
    logic [FDE_FRAC_W-1:0] frac;
    logic                  wfr;
    logic                  wff;
    logic [FDE_FRAC_W-1:0] phase;
  } fde_fields_t;
endpackage

// File: rtl/fde_field_calc.sv
module fde_field_calc
  import fde_pkg::*;
#(
  parameter int CNT_W  = FDE_CNT_W,
  parameter int FRAC_W = FDE_FRAC_W,
  localparam int DIV_W = CNT_W + 1
) (
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output fde_fields_t       fields,
  output logic              bad
);
  localparam logic [DIV_W-1:0] MAX_DIV = DIV_W'((2 ** CNT_W - 1) * 2);

  logic [CNT_W-1:0] half_c;
  logic             odd;
  logic             frac_one;
  logic             is_two;

  assign half_c   = div_int[DIV_W-1:1];
  assign odd      = div_int[0];
  assign frac_one = (div_frac == FRAC_W'(1));
  assign is_two   = (div_int == DIV_W'(2));
  assign bad      = (div_int == '0) || (div_int > MAX_DIV);

  always_comb begin
    fields = '0;
    if (bad) begin
      fields = '0;
    end else if (div_int == DIV_W'(1)) begin
      fields.nocnt = 1'b1;
    end else if (div_frac == '0) begin
      fields.hi     = half_c;
      fields.edge_b = odd;
      fields.lo     = div_int[CNT_W-1:0] - half_c;
    end else begin
      fields.fen    = 1'b1;
      fields.frac   = div_frac;
      fields.edge_b = odd;
      fields.hi     = odd ? half_c : half_c - CNT_W'(1);
      fields.wfr    = ~odd;
      fields.lo     = (~odd || frac_one) ? half_c - CNT_W'(1) : half_c;
      fields.wff    = ((~odd) ^ frac_one) || (is_two && frac_one);
      fields.phase  = {odd, div_frac[FRAC_W-1:1]};
    end
  end
endmodule

// File: rtl/fde_word_pack.sv
module fde_word_pack
  import fde_pkg::*;
#(
  parameter int WORD_W = FDE_WORD_W
) (
  input  fde_fields_t       fields,
  output logic [WORD_W-1:0] word1,
  output logic [WORD_W-1:0] word2,
  output logic [WORD_W-1:0] word3
);
  always_comb begin
    word1 = '0;
    word1[W1_HI_LSB +: FDE_CNT_W] = fields.hi;
    word1[W1_LO_LSB +: FDE_CNT_W] = fields.lo;

    word2 = '0;
    word2[W2_FRAC_LSB +: FDE_FRAC_W] = fields.frac;
    word2[W2_FEN_BIT]   = fields.fen;
    word2[W2_WFR_BIT]   = fields.wfr;
    word2[W2_EDGE_BIT]  = fields.edge_b;
    word2[W2_NOCNT_BIT] = fields.nocnt;

    word3 = '0;
    word3[W3_PHASE_LSB +: FDE_FRAC_W] = fields.phase;
    word3[W3_WFF_BIT] = fields.wff;
  end
endmodule

// File: rtl/frac_div_encoder.sv
module frac_div_encoder
  import fde_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [FDE_DIV_W-1:0]  div_int,
  input  logic [FDE_FRAC_W-1:0] div_frac,
  output logic                  out_valid,
  output logic [FDE_CNT_W-1:0]  hi_cnt,
  output logic [FDE_CNT_W-1:0]  lo_cnt,
  output logic                  edge_bit,
  output logic                  bypass,
  output logic                  frac_en,
  output logic [FDE_FRAC_W-1:0] frac_val,
  output logic                  wf_rise,
  output logic                  wf_fall,
  output logic [FDE_FRAC_W-1:0] frac_phase,
  output logic [FDE_WORD_W-1:0] cfg_word1,
  output logic [FDE_WORD_W-1:0] cfg_word2,
  output logic [FDE_WORD_W-1:0] cfg_word3,
  output logic                  bad_div
);
  fde_fields_t           nxt_f, cur_f;
  logic                  nxt_bad;
  logic [FDE_WORD_W-1:0] nxt_w1, nxt_w2, nxt_w3;

  fde_field_calc #(.CNT_W(FDE_CNT_W), .FRAC_W(FDE_FRAC_W)) u_calc (
    .div_int (div_int),
    .div_frac(div_frac),
    .fields  (nxt_f),
    .bad     (nxt_bad)
  );

  fde_word_pack #(.WORD_W(FDE_WORD_W)) u_pack (
    .fields(nxt_f),
    .word1 (nxt_w1),
    .word2 (nxt_w2),
    .word3 (nxt_w3)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cur_f     <= '0;
      bad_div   <= 1'b0;
      cfg_word1 <= '0;
      cfg_word2 <= '0;
      cfg_word3 <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cur_f     <= nxt_f;
        bad_div   <= nxt_bad;
        cfg_word1 <= nxt_w1;
        cfg_word2 <= nxt_w2;
        cfg_word3 <= nxt_w3;
      end
    end
  end

  assign hi_cnt     = cur_f.hi;
  assign lo_cnt     = cur_f.lo;
  assign edge_bit   = cur_f.edge_b;
  assign bypass     = cur_f.nocnt;
  assign frac_en    = cur_f.fen;
  assign frac_val   = cur_f.frac;
  assign wf_rise    = cur_f.wfr;
  assign wf_fall    = cur_f.wff;
  assign frac_phase = cur_f.phase;

  // R1: one-cycle handshake
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cfg_word1) && $stable(cfg_word2) && $stable(cfg_word3)));
  // R3: bypass excludes every other field
  assert_bypass_alone_R3: assert property (@(posedge clk) disable iff (rst)
    bypass |-> (hi_cnt == '0 && lo_cnt == '0 && !frac_en && !edge_bit && frac_phase == '0));
  // R4: integer split sums back to the ratio
  assert_int_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !frac_en && !bypass && !bad_div)
      |-> ({1'b0, hi_cnt} + {1'b0, lo_cnt} == $past(div_int)));
  // R5: fraction enable tracks a nonzero fraction
  assert_fen_R5: assert property (@(posedge clk) disable iff (rst)
    frac_en |-> (frac_val != '0));
  // R13: invalid ratio clears the words
  assert_bad_zero_R13: assert property (@(posedge clk) disable iff (rst)
    bad_div |-> (cfg_word1 == '0 && cfg_word2 == '0 && cfg_word3 == '0));
endmodule

// File: tb/frac_div_encoder_bench.sv
module frac_div_encoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [6:0]  div_int;
  logic [2:0]  div_frac;
  logic        out_valid, edge_bit, bypass, frac_en, wf_rise, wf_fall, bad_div;
  logic [5:0]  hi_cnt, lo_cnt;
  logic [2:0]  frac_val, frac_phase;
  logic [15:0] cfg_word1, cfg_word2, cfg_word3;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  frac_div_encoder u_frac_div_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .div_int(div_int), .div_frac(div_frac),
    .out_valid(out_valid), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .edge_bit(edge_bit),
    .bypass(bypass), .frac_en(frac_en), .frac_val(frac_val), .wf_rise(wf_rise),
    .wf_fall(wf_fall), .frac_phase(frac_phase), .cfg_word1(cfg_word1),
    .cfg_word2(cfg_word2), .cfg_word3(cfg_word3), .bad_div(bad_div)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected fields from the requirement text
  task automatic send_and_check(input int n, input int f);
    int hi, lo, ed, nc, fe, fr, wr, wfv, ph, bad;
    hi = 0; lo = 0; ed = 0; nc = 0; fe = 0; fr = 0; wr = 0; wfv = 0; ph = 0; bad = 0;
    if (n == 0 || n > 126) bad = 1;
    else if (n == 1) nc = 1;
    else if (f == 0) begin
      hi = n / 2; ed = n % 2; lo = n - hi;
    end else begin
      fe = 1; fr = f; hi = n / 2; ed = n % 2; lo = hi;
      if (ed == 0) begin hi = hi - 1; wr = 1; end
      if (ed == 0 || f == 1) lo = lo - 1;
      if (((ed == 0) != (f == 1)) || (n == 2 && f == 1)) wfv = 1;
      ph = ed * 4 + f / 2;
    end
    @(negedge clk);
    in_valid = 1'b1; div_int = 7'(n); div_frac = 3'(f);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid", int'(out_valid), 1);
    check("R13 bad_div", int'(bad_div), bad);
    check("R3 bypass", int'(bypass), nc);
    check("R4 R6 hi_cnt", int'(hi_cnt), hi);
    check("R4 R7 lo_cnt", int'(lo_cnt), lo);
    check("R5 edge/fen/frac", int'({edge_bit, frac_en, frac_val}), ed * 16 + fe * 8 + fr);
    check("R6 wf_rise", int'(wf_rise), wr);
    check("R8 wf_fall", int'(wf_fall), wfv);
    check("R9 phase", int'(frac_phase), ph);
    check("R10 word1", int'(cfg_word1), (hi << 6) | lo);
    check("R11 word2", int'(cfg_word2), (fr << 12) | (fe << 11) | (wr << 10) | (ed << 7) | (nc << 6));
    check("R12 word3", int'(cfg_word3), (ph << 11) | (wfv << 10));
  endtask

  task automatic t_reset();
    check("R2 reset valid", int'(out_valid), 0);
    check("R2 reset words", int'(cfg_word1 | cfg_word2 | cfg_word3), 0);
    check("R2 reset fields", int'({hi_cnt, lo_cnt, bypass, frac_en, bad_div}), 0);
  endtask

  task automatic t_integer();
    send_and_check(4, 0);
    send_and_check(5, 0);
    send_and_check(126, 0);
    send_and_check(2, 0);
  endtask

  task automatic t_bypass();
    send_and_check(1, 0);
    send_and_check(1, 5);
  endtask

  task automatic t_fractional();
    send_and_check(4, 3);
    send_and_check(5, 1);
    send_and_check(2, 1);
    send_and_check(5, 4);
    send_and_check(3, 7);
    send_and_check(6, 1);
    send_and_check(2, 6);
  endtask

  task automatic t_invalid();
    send_and_check(0, 3);
    send_and_check(127, 0);
  endtask

  task automatic t_hold();
    logic [15:0] w1, w2, w3;
    send_and_check(9, 2);
    w1 = cfg_word1; w2 = cfg_word2; w3 = cfg_word3;
    @(negedge clk);
    div_int = 7'd20; div_frac = 3'd0;
    @(negedge clk);
    check("R1 valid drops", int'(out_valid), 0);
    check("R1 word1 held", int'(cfg_word1), int'(w1));
    check("R1 word2 held", int'(cfg_word2), int'(w2));
    check("R1 word3 held", int'(cfg_word3), int'(w3));
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; div_int = '0; div_frac = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_integer();
    t_bypass();
    t_fractional();
    t_invalid();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule